// File: doc/BRIEF.md
# Pipelined Write-Readback Bus Master

This block is a bus master for the AHB-Lite protocol. It turns a simple command (address, write data, transfer size and an operation code) into single transfers on the bus. Three operations exist: a plain read, a plain write, and a write followed by a read of the same address. The third operation checks that the written data landed where it was meant to go.

Every transfer has two phases. In the address phase the master drives the address and the control signals. In the data phase the slave moves the data and returns its response. The phases are pipelined, so the address phase of one transfer overlaps the data phase of the one before it. For the write-readback operation the master places the read's address phase in the cycle right after the write's address phase is taken. No idle cycle separates the two. While the slave holds HREADY low, the master keeps the pending address phase and the write data frozen.

When the last data phase of a command finishes, the master returns a one-cycle done pulse and, for reads, the sampled read data. An ERROR response sets a sticky flag together with the done pulse. The master then cancels its pending address phase and issues no further transfers until reset.

Top module: `rbk_ahb_master`

## Requirements
- R1: During and right after reset, HTRANS is IDLE (2'b00), cmd_ready is high, and rsp_done and err_flag are low.
- R2: HBURST is always SINGLE (3'b000), and HSIZE during an address phase equals the cmd_size given with the command.
- R3: While HTRANS is NONSEQ (2'b10) and HREADY is low with no error response, the next cycle still shows NONSEQ with the same HADDR, HWRITE and HSIZE.
- R4: For a write, HWDATA carries the command's write data from the cycle after its address phase is accepted until the cycle in which HREADY is high.
- R5: cmd_op selects the operation: 2'b00 read, 2'b01 write, 2'b11 write then readback (2'b10 acts as a read). For 2'b11, the cycle after the write address phase is accepted shows a NONSEQ read to the same HADDR.
- R6: After the last address phase of the last command is accepted, HTRANS shows IDLE in the next cycle. A write-readback pair therefore shows NONSEQ, NONSEQ, IDLE when the slave has no wait states.
- R7: rsp_done is a single-cycle pulse in the cycle after the last data phase of a command completes (HREADY high). For a read, rsp_rdata then holds the HRDATA sampled at that completion.
- R8: A write-readback returns the written data for any number of slave wait states.
- R9: cmd_ready is low while a NONSEQ address phase is stalled by HREADY low.
- R10: When a data phase gets an ERROR response (HRESP high), the master drives IDLE from the next cycle on. It pulses rsp_done and sets err_flag at completion, and after that keeps cmd_ready low and HTRANS IDLE until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command taken on this edge when valid |
| cmd_op | input | 2 | Operation code |
| cmd_addr | input | AW | Transfer address |
| cmd_wdata | input | DW | Write data |
| cmd_size | input | 3 | Transfer size code |
| rsp_done | output | 1 | Command finished pulse |
| rsp_rdata | output | DW | Read data of the last read |
| err_flag | output | 1 | Sticky error response seen |
| haddr | output | AW | Bus address |
| hwrite | output | 1 | Bus direction, high for write |
| hsize | output | 3 | Bus transfer size |
| hburst | output | 3 | Burst type, always SINGLE |
| htrans | output | 2 | Transfer type, IDLE or NONSEQ |
| hwdata | output | DW | Bus write data |
| hready | input | 1 | Slave ready, ends a data phase |
| hresp | input | 1 | Slave error response |
| hrdata | input | DW | Bus read data |

## Verification
Write-readback pairs run against a slave model with zero wait states, with a fixed count of three, and with a random count for each transfer. Zero waits shows the NONSEQ, NONSEQ, IDLE sequence with no gap. Fixed and random waits show that the address phase, HWDATA and cmd_ready stay held until the write completes, and that the readback still returns the written word. Separate single writes and reads place the done pulse exactly one cycle after the read completes. A back-to-back pair of writes under waits shows that a stalled address phase blocks the next command. A pair aimed at an erroring address shows the readback being cancelled and the master going quiet.

// File: rtl/rbk_ahb_master.sv
module rbk_ahb_master #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          hclk,
  input  logic          hresetn,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [2:0]    cmd_size,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic          err_flag,
  output logic [AW-1:0] haddr,
  output logic          hwrite,
  output logic [2:0]    hsize,
  output logic [2:0]    hburst,
  output logic [1:0]    htrans,
  output logic [DW-1:0] hwdata,
  input  logic          hready,
  input  logic          hresp,
  input  logic [DW-1:0] hrdata
);
  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_NONSEQ = 2'b10;

  logic          ap_valid, ap_write, ap_rb;
  logic [AW-1:0] ap_addr;
  logic [2:0]    ap_size;
  logic [DW-1:0] ap_wdata;
  logic          dp_valid, dp_write, dp_last;
  logic [DW-1:0] dp_wdata;

  wire dp_err   = dp_valid && hresp;
  wire cancel   = dp_err && !hready;
  wire take     = cmd_valid && cmd_ready;
  wire rb_issue = hready && ap_valid && ap_rb;

  assign cmd_ready = !err_flag && !dp_err && (!ap_valid || (hready && !ap_rb));

  assign htrans = ap_valid ? TR_NONSEQ : TR_IDLE;
  assign haddr  = ap_addr;
  assign hwrite = ap_write;
  assign hsize  = ap_size;
  assign hburst = 3'b000;
  assign hwdata = dp_wdata;

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      ap_valid  <= 1'b0;
      ap_write  <= 1'b0;
      ap_rb     <= 1'b0;
      ap_addr   <= '0;
      ap_size   <= '0;
      ap_wdata  <= '0;
      dp_valid  <= 1'b0;
      dp_write  <= 1'b0;
      dp_last   <= 1'b0;
      dp_wdata  <= '0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
      err_flag  <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      if (dp_valid && hready) begin
        if (dp_last || hresp) rsp_done <= 1'b1;
        if (!dp_write) rsp_rdata <= hrdata;
        if (hresp) err_flag <= 1'b1;
      end
      if (hready) begin
        dp_valid <= ap_valid;
        dp_write <= ap_write;
        dp_last  <= !ap_rb;
        dp_wdata <= ap_wdata;
      end
      if (cancel) begin
        ap_valid <= 1'b0;
      end else if (rb_issue) begin
        ap_write <= 1'b0;
        ap_rb    <= 1'b0;
      end else if (take) begin
        ap_valid <= 1'b1;
        ap_write <= cmd_op[0];
        ap_rb    <= &cmd_op;
        ap_addr  <= cmd_addr;
        ap_size  <= cmd_size;
        ap_wdata <= cmd_wdata;
      end else if (hready) begin
        ap_valid <= 1'b0;
      end
    end
  end

  p_addr_hold_r3: assert property (@(posedge hclk) disable iff (!hresetn)
    (htrans == TR_NONSEQ && !hready && !hresp) |=>
      (htrans == TR_NONSEQ && $stable(haddr) && $stable(hwrite) && $stable(hsize)));

  p_wdata_hold_r4: assert property (@(posedge hclk) disable iff (!hresetn)
    (dp_valid && dp_write && !hready) |=> $stable(hwdata));

  p_readback_next_r5: assert property (@(posedge hclk) disable iff (!hresetn)
    (htrans == TR_NONSEQ && hready && hwrite && ap_rb && !hresp) |=>
      (htrans == TR_NONSEQ && !hwrite && haddr == $past(haddr)));

  p_done_after_phase_r7: assert property (@(posedge hclk) disable iff (!hresetn)
    rsp_done |-> $past(dp_valid && hready));

  p_cancel_idle_r10: assert property (@(posedge hclk) disable iff (!hresetn)
    (dp_valid && hresp && !hready) |=> htrans == TR_IDLE);

  p_err_quiet_r10: assert property (@(posedge hclk) disable iff (!hresetn)
    err_flag |-> (htrans == TR_IDLE && !cmd_ready));
endmodule

// File: tb/sim_rbk_ahb_master.sv
module sim_rbk_ahb_master;
  localparam int CLK_NS = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [AW-1:0] ERR_A = 32'h0000_0038;

  logic clk = 1'b0;
  logic rstn = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'b00;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic [2:0]    cmd_size = 3'b010;
  logic          rsp_done, err_flag;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] haddr;
  logic          hwrite, hready, hresp;
  logic [2:0]    hsize, hburst;
  logic [1:0]    htrans;
  logic [DW-1:0] hwdata, hrdata;

  rbk_ahb_master #(.AW(AW), .DW(DW)) u0 (
    .hclk(clk), .hresetn(rstn),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_size(cmd_size),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .err_flag(err_flag),
    .haddr(haddr), .hwrite(hwrite), .hsize(hsize), .hburst(hburst),
    .htrans(htrans), .hwdata(hwdata),
    .hready(hready), .hresp(hresp), .hrdata(hrdata)
  );

  // slave model
  logic [DW-1:0] mem [16];
  logic          s_act, s_wr;
  logic [AW-1:0] s_addr;
  int            s_wait;
  int            ws_cfg = 0;

  assign hready = !(s_act && s_wait != 0);
  assign hresp  = s_act && s_addr == ERR_A;
  assign hrdata = mem[s_addr[5:2]];

  always @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      s_act <= 1'b0; s_wr <= 1'b0; s_addr <= '0; s_wait <= 0;
    end else if (hready) begin
      if (s_act && s_wr && !hresp) mem[s_addr[5:2]] <= hwdata;
      if (htrans == 2'b10) begin
        s_act  <= 1'b1;
        s_wr   <= hwrite;
        s_addr <= haddr;
        s_wait <= (haddr == ERR_A) ? 1 : (ws_cfg < 0 ? int'($urandom_range(0, 4)) : ws_cfg);
      end else begin
        s_act <= 1'b0;
      end
    end else begin
      s_wait <= s_wait - 1;
    end
  end

  int nchk = 0;
  int nbad = 0;

  task automatic ck(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [2:0] sz);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_size = sz;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    @(negedge clk);
    while ((s_act || htrans != 2'b00) && n < 100) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    ck(htrans == 2'b00, "R1 htrans", 32'(htrans), 0);
    ck(cmd_ready == 1'b1, "R1 cmd_ready", 32'(cmd_ready), 1);
    ck(rsp_done == 1'b0 && err_flag == 1'b0, "R1 done/err", {rsp_done, err_flag}, 0);
  endtask

  // write-readback with per-cycle protocol checks
  task automatic t_pair(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [2:0] sz, input bit seq_chk);
    bit wacc = 0, racc = 0, in_wdp = 0, stall = 0, got = 0;
    int cyc = 0, tr_idx = 0;
    logic [1:0] seq [3];
    logic [AW-1:0] st_a = '0;
    logic st_w = 1'b0;
    send(2'b11, a, d, sz);
    while (!got && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (seq_chk && tr_idx < 3) begin seq[tr_idx] = htrans; tr_idx++; end
      if (stall)
        ck(htrans == 2'b10 && haddr == st_a && hwrite == st_w, "R3 held phase", haddr, st_a);
      if (wacc) begin
        ck(htrans == 2'b10 && !hwrite && haddr == a, "R5 readback next cycle", {htrans, hwrite}, {2'b10, 1'b0});
        in_wdp = 1;
      end
      if (racc) ck(htrans == 2'b00, "R6 idle after pair", 32'(htrans), 0);
      if (in_wdp) ck(hwdata == d, "R4 hwdata held", hwdata, d);
      if (in_wdp && hready) in_wdp = 0;
      if (htrans == 2'b10 && hwrite && hready)
        ck(hsize == sz && hburst == 3'b000, "R2 size/burst", {hburst, hsize}, {3'b000, sz});
      if (htrans == 2'b10 && !hready)
        ck(cmd_ready == 1'b0, "R9 ready low in stall", 32'(cmd_ready), 0);
      stall = (htrans == 2'b10 && !hready && !hresp);
      st_a = haddr; st_w = hwrite;
      wacc = (htrans == 2'b10 && hready && hwrite);
      racc = (htrans == 2'b10 && hready && !hwrite);
      if (rsp_done) got = 1;
    end
    ck(got, "R7 done seen", 32'(got), 1);
    ck(rsp_rdata == d, "R8 readback data", rsp_rdata, d);
    if (seq_chk)
      ck(seq[0] == 2'b10 && seq[1] == 2'b10 && seq[2] == 2'b00, "R6 NONSEQ,NONSEQ,IDLE",
         {26'd0, seq[0], seq[1], seq[2]}, {26'd0, 6'b101000});
    drain();
  endtask

  task automatic t_single(input logic [AW-1:0] a, input logic [DW-1:0] d, input int ws);
    bit fin = 0;
    int cyc = 0;
    ws_cfg = ws;
    send(2'b01, a, d, 3'b010);
    drain();
    send(2'b00, a, 32'h0, 3'b010);
    while (!fin && cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (rsp_done) ck(1'b0, "R7 early done", 32'(rsp_done), 0);
      if (s_act && !s_wr && hready) begin
        fin = 1;
        @(negedge clk);
        ck(rsp_done == 1'b1, "R7 done one cycle later", 32'(rsp_done), 1);
        ck(rsp_rdata == d, "R7 read data", rsp_rdata, d);
        @(negedge clk);
        ck(rsp_done == 1'b0, "R7 single pulse", 32'(rsp_done), 0);
      end
    end
    ck(fin, "R7 read completed", 32'(fin), 1);
    drain();
  endtask

  task automatic t_stall();
    bit seen = 0;
    int cyc = 0;
    ws_cfg = 3;
    send(2'b01, 32'h10, 32'hAAAA_0001, 3'b010);
    send(2'b01, 32'h14, 32'hAAAA_0002, 3'b010);
    while (cyc < 20) begin
      @(negedge clk);
      cyc++;
      if (htrans == 2'b10 && !hready) begin
        seen = 1;
        ck(cmd_ready == 1'b0, "R9 ready while stalled", 32'(cmd_ready), 0);
        ck(haddr == 32'h14, "R3 stalled address", haddr, 32'h14);
      end
    end
    ck(seen, "R9 stall observed", 32'(seen), 1);
    drain();
    ws_cfg = 0;
    t_pair(32'h10, 32'hAAAA_0001, 3'b010, 0);
  endtask

  task automatic t_error();
    bit rd_acc = 0, got = 0;
    int cyc = 0;
    ws_cfg = 0;
    send(2'b11, ERR_A, 32'hDEAD_BEEF, 3'b010);
    while (cyc < 20) begin
      @(negedge clk);
      cyc++;
      if (htrans == 2'b10 && !hwrite && hready) rd_acc = 1;
      if (hresp && !hready) begin
        @(negedge clk);
        cyc++;
        ck(htrans == 2'b00, "R10 idle after error", 32'(htrans), 0);
      end
      if (rsp_done) begin
        got = 1;
        ck(err_flag == 1'b1, "R10 err with done", 32'(err_flag), 1);
      end
    end
    ck(got, "R10 done on error", 32'(got), 1);
    ck(!rd_acc, "R10 readback cancelled", 32'(rd_acc), 0);
    ck(err_flag && cmd_ready == 1'b0 && htrans == 2'b00, "R10 quiet after error",
       {err_flag, cmd_ready, htrans}, 32'b1000);
  endtask

  bit fin_all = 0;

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rstn = 1'b1;
    @(negedge clk);
    t_reset();
    ws_cfg = 0;
    t_pair(32'h04, 32'h1234_5678, 3'b010, 1);
    t_pair(32'h08, 32'h0000_BEEF, 3'b001, 1);
    ws_cfg = 3;
    t_pair(32'h0C, 32'hCAFE_F00D, 3'b010, 0);
    t_single(32'h20, 32'h5555_AAAA, 0);
    t_single(32'h24, 32'h0F0F_0F0F, 2);
    ws_cfg = -1;
    for (int k = 0; k < 12; k++)
      t_pair({26'd0, 4'(k), 2'b00}, $urandom, 3'b010, 0);
    t_stall();
    t_error();
    fin_all = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin_all) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule